// File: doc/BRIEF.md
# Byte Rotate, Shift and Bit-Manipulation Unit

This unit performs single-byte rotates, shifts, a nibble exchange and single-bit test, clear and set operations. The caller presents an 8-bit operand, the current flag nibble, a 4-bit operation select and a 3-bit bit index, then raises `start` for one cycle. On the next cycle `done` pulses high. At that point the result byte, the new flag nibble and a write-back enable are held in output registers. They stay there until the next start.

The datapath is purely combinational. One register stage sits at the output. Fetching the operand and writing the result back belong to the surrounding core, and this unit does neither. Four accumulator short-form rotates are separate operation codes. They produce the same byte as their general counterparts, but they always report Z as 0.

The flag nibble is packed as bit 3 = Z, bit 2 = N, bit 1 = H and bit 0 = C, on both `flagsIn` and `flagsOut`.

Operation codes on `opSel`:

| Code | Operation |
|------|-----------|
| 0 | circular rotate left |
| 1 | circular rotate right |
| 2 | rotate left through carry |
| 3 | rotate right through carry |
| 4 | shift left, zero in |
| 5 | arithmetic shift right |
| 6 | nibble swap |
| 7 | logical shift right |
| 8 | bit test |
| 9 | bit clear |
| 10 | bit set |
| 11 | short circular left |
| 12 | short circular right |
| 13 | short through-carry left |
| 14 | short through-carry right |
| 15 | reserved |

Top module: `bitop_unit`

## Requirements
- R1: After reset `resultOut`, `flagsOut`, `writeEn` and `done` are all 0.
- R2: `done` is high for exactly the one cycle after a cycle with `start` high. While `start` stays low, the outputs hold their values whatever the other inputs do.
- R3: Through-carry rotates work as follows. Code 2 gives result {op[6:0], Cin} with C = op[7]. Code 3 gives result {Cin, op[7:1]} with C = op[0].
- R4: Circular rotates work as follows. Code 0 gives result {op[6:0], op[7]} with C = op[7]. Code 1 gives result {op[0], op[7:1]} with C = op[0].
- R5: Shifts work as follows. Code 4 gives {op[6:0], 0} with C = op[7]. Code 5 gives {op[7], op[7:1]} with C = op[0]. Code 7 gives {0, op[7:1]} with C = op[0].
- R6: Codes 0 to 5 and 7 set Z when the result byte is zero. They clear N and H, and they assert `writeEn`.
- R7: Codes 11, 12, 13 and 14 give the same result byte and C as codes 0, 1, 2 and 3 respectively. They always clear Z, N and H.
- R8: Code 6 exchanges the two nibbles. It sets Z from the result, clears N, H and C, and asserts `writeEn`.
- R9: Code 8 sets Z when operand bit `bitIdx` is 0. It clears N, sets H and passes C unchanged. The result equals the operand and `writeEn` is 0.
- R10: Codes 9 and 10 clear or set operand bit `bitIdx`, where index 0 is the least significant bit. They pass all four flags unchanged and assert `writeEn`.
- R11: Code 15 returns the operand and the input flags unchanged, with `writeEn` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture strobe for the current operation |
| opSel | input | 4 | Operation code |
| bitIdx | input | 3 | Bit index for codes 8 to 10 |
| operand | input | 8 | Source byte |
| flagsIn | input | 4 | Current flags {Z,N,H,C} |
| resultOut | output | 8 | Registered result byte |
| flagsOut | output | 4 | Registered new flags {Z,N,H,C} |
| writeEn | output | 1 | Result should be written back |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every operation completes in one registered step, so a wrong decode or a wrong fill bit shows at the ports on the very cycle `done` rises. The bench samples exactly there. A wrong decode shows as a wrong result byte, a misplaced flag or a wrong write-back enable. A stale or mis-gated capture register shows only in later cycles, as outputs that change while `start` is low. The bench therefore watches the held values for several idle cycles while it changes the inputs.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int FLAG_Z = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_H = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [3:0] {
    OP_RLC  = 4'd0,
    OP_RRC  = 4'd1,
    OP_RL   = 4'd2,
    OP_RR   = 4'd3,
    OP_SLA  = 4'd4,
    OP_SRA  = 4'd5,
    OP_SWAP = 4'd6,
    OP_SRL  = 4'd7,
    OP_TEST = 4'd8,
    OP_CLR  = 4'd9,
    OP_SETB = 4'd10,
    OP_QRLC = 4'd11,
    OP_QRRC = 4'd12,
    OP_QRL  = 4'd13,
    OP_QRR  = 4'd14,
    OP_NONE = 4'd15
  } opCode_e;

  typedef enum logic [2:0] {
    UNIT_SHIFT,
    UNIT_SWAP,
    UNIT_TEST,
    UNIT_WRITE,
    UNIT_PASS
  } unitSel_e;

  typedef enum logic [1:0] {
    FILL_ZERO,
    FILL_CARRY,
    FILL_WRAP,
    FILL_SIGN
  } fillSel_e;

  typedef struct packed {
    logic     capture;
    unitSel_e unit;
    logic     dirRight;
    fillSel_e fill;
    logic     zForce0;
    logic     bitVal;
    logic     wbEn;
  } bitopCtrl_t;
endpackage

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] opSel,
  output bitopCtrl_t ctrl,
  output logic       done
);
  always_comb begin
    ctrl          = '0;
    ctrl.capture  = start;
    ctrl.unit     = UNIT_SHIFT;
    ctrl.fill     = FILL_ZERO;
    ctrl.wbEn     = 1'b1;
    unique case (opCode_e'(opSel))
      OP_RLC, OP_QRLC: ctrl.fill = FILL_WRAP;
      OP_RRC, OP_QRRC: begin
        ctrl.fill     = FILL_WRAP;
        ctrl.dirRight = 1'b1;
      end
      OP_RL, OP_QRL: ctrl.fill = FILL_CARRY;
      OP_RR, OP_QRR: begin
        ctrl.fill     = FILL_CARRY;
        ctrl.dirRight = 1'b1;
      end
      OP_SLA: ctrl.fill = FILL_ZERO;
      OP_SRA: begin
        ctrl.fill     = FILL_SIGN;
        ctrl.dirRight = 1'b1;
      end
      OP_SRL: begin
        ctrl.fill     = FILL_ZERO;
        ctrl.dirRight = 1'b1;
      end
      OP_SWAP: ctrl.unit = UNIT_SWAP;
      OP_TEST: begin
        ctrl.unit = UNIT_TEST;
        ctrl.wbEn = 1'b0;
      end
      OP_CLR: begin
        ctrl.unit   = UNIT_WRITE;
        ctrl.bitVal = 1'b0;
      end
      OP_SETB: begin
        ctrl.unit   = UNIT_WRITE;
        ctrl.bitVal = 1'b1;
      end
      default: begin
        ctrl.unit = UNIT_PASS;
        ctrl.wbEn = 1'b0;
      end
    endcase
    if (opSel >= OP_QRLC && opSel <= OP_QRR) ctrl.zForce0 = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end
endmodule

// File: rtl/bitop_datapath.sv
module bitop_datapath
  import bitop_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDXW = $clog2(WIDTH),
  localparam int NIB  = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  bitopCtrl_t       ctrl,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic [WIDTH-1:0] operand,
  input  logic [3:0]       flagsIn,
  output logic [WIDTH-1:0] resultOut,
  output logic [3:0]       flagsOut,
  output logic             writeEn
);
  logic [WIDTH-1:0] bitMask;
  logic [WIDTH-1:0] shiftRes;
  logic [WIDTH-1:0] nextRes;
  logic [3:0]       nextFlags;
  logic             fillBit;
  logic             carryOut;

  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign bitMask[i] = (bitIdx == IDXW'(i));
  end

  always_comb begin
    unique case (ctrl.fill)
      FILL_CARRY: fillBit = flagsIn[FLAG_C];
      FILL_WRAP:  fillBit = ctrl.dirRight ? operand[0] : operand[WIDTH-1];
      FILL_SIGN:  fillBit = operand[WIDTH-1];
      default:    fillBit = 1'b0;
    endcase
    if (ctrl.dirRight) begin
      shiftRes = {fillBit, operand[WIDTH-1:1]};
      carryOut = operand[0];
    end else begin
      shiftRes = {operand[WIDTH-2:0], fillBit};
      carryOut = operand[WIDTH-1];
    end
  end

  always_comb begin
    nextRes   = operand;
    nextFlags = flagsIn;
    unique case (ctrl.unit)
      UNIT_SHIFT: begin
        nextRes           = shiftRes;
        nextFlags[FLAG_Z] = ~ctrl.zForce0 & (shiftRes == '0);
        nextFlags[FLAG_N] = 1'b0;
        nextFlags[FLAG_H] = 1'b0;
        nextFlags[FLAG_C] = carryOut;
      end
      UNIT_SWAP: begin
        nextRes   = {operand[NIB-1:0], operand[WIDTH-1:NIB]};
        nextFlags = {(operand == '0), 3'b000};
      end
      UNIT_TEST: begin
        nextFlags[FLAG_Z] = ~|(operand & bitMask);
        nextFlags[FLAG_N] = 1'b0;
        nextFlags[FLAG_H] = 1'b1;
      end
      UNIT_WRITE: begin
        nextRes = ctrl.bitVal ? (operand | bitMask) : (operand & ~bitMask);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
      flagsOut  <= '0;
      writeEn   <= 1'b0;
    end else if (ctrl.capture) begin
      resultOut <= nextRes;
      flagsOut  <= nextFlags;
      writeEn   <= ctrl.wbEn;
    end
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [3:0]       opSel,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic [WIDTH-1:0] operand,
  input  logic [3:0]       flagsIn,
  output logic [WIDTH-1:0] resultOut,
  output logic [3:0]       flagsOut,
  output logic             writeEn,
  output logic             done
);
  bitopCtrl_t ctrl;

  bitop_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .opSel (opSel),
    .ctrl  (ctrl),
    .done  (done)
  );

  bitop_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .bitIdx    (bitIdx),
    .operand   (operand),
    .flagsIn   (flagsIn),
    .resultOut (resultOut),
    .flagsOut  (flagsOut),
    .writeEn   (writeEn)
  );
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk
  import bitop_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDXW = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [3:0]       opSel,
  input logic [IDXW-1:0]  bitIdx,
  input logic [WIDTH-1:0] operand,
  input logic [3:0]       flagsIn,
  input logic [WIDTH-1:0] resultOut,
  input logic [3:0]       flagsOut,
  input logic             writeEn,
  input logic             done
);
  // R2
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(start) |-> ($stable(resultOut) && $stable(flagsOut) && $stable(writeEn)));

  // R6
  shift_nh_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(opSel) <= 4'd7) |-> (flagsOut[FLAG_N] == 1'b0 && flagsOut[FLAG_H] == 1'b0));

  // R7
  short_z_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(opSel) >= 4'd11 && $past(opSel) <= 4'd14) |-> !flagsOut[FLAG_Z]);

  // R8
  swap_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(opSel) == 4'd6) |->
      (resultOut == {$past(operand[WIDTH/2-1:0]), $past(operand[WIDTH-1:WIDTH/2])}));

  // R9
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(opSel) == 4'd8) |-> (!writeEn && flagsOut[FLAG_H] &&
      flagsOut[FLAG_C] == $past(flagsIn[FLAG_C])));

  // R10
  bitwrite_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && ($past(opSel) == 4'd9 || $past(opSel) == 4'd10)) |->
      (flagsOut == $past(flagsIn) && writeEn));

  // R11
  reserved_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(opSel) == 4'd15) |->
      (resultOut == $past(operand) && !writeEn));
endmodule

bind bitop_unit bitop_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] opSel = '0;
  logic [2:0] bitIdx = '0;
  logic [7:0] operand = '0;
  logic [3:0] flagsIn = '0;
  logic [7:0] resultOut;
  logic [3:0] flagsOut;
  logic       writeEn;
  logic       done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bitop_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .bitIdx(bitIdx),
    .operand(operand), .flagsIn(flagsIn), .resultOut(resultOut),
    .flagsOut(flagsOut), .writeEn(writeEn), .done(done)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected {wb, result, Z, N, H, C} from the requirement text
  function automatic logic [12:0] model(input int op, input logic [7:0] v,
                                        input int idx, input logic [3:0] f);
    logic [7:0] r = v;
    logic z = f[3], n = f[2], h = f[1], c = f[0];
    logic wb = 1'b1;
    case (op)
      0, 11: begin r = {v[6:0], v[7]}; c = v[7]; end
      1, 12: begin r = {v[0], v[7:1]}; c = v[0]; end
      2, 13: begin r = {v[6:0], f[0]}; c = v[7]; end
      3, 14: begin r = {f[0], v[7:1]}; c = v[0]; end
      4: begin r = v << 1; c = v[7]; end
      5: begin r = {v[7], v[7:1]}; c = v[0]; end
      7: begin r = v >> 1; c = v[0]; end
      6: begin r = {v[3:0], v[7:4]}; c = 0; end
      8: begin z = (v[idx] == 1'b0); n = 0; h = 1; wb = 0; end
      9: r[idx] = 1'b0;
      10: r[idx] = 1'b1;
      default: wb = 0;
    endcase
    if (op <= 7) begin z = (r == 8'h00); n = 0; h = 0; end
    if (op >= 11 && op <= 14) begin z = 0; n = 0; h = 0; end
    return {wb, r, z, n, h, c};
  endfunction

  task automatic runOp(input string req, input int op, input logic [7:0] v,
                       input int idx, input logic [3:0] f);
    logic [12:0] e;
    e = model(op, v, idx, f);
    @(negedge clk);
    opSel = 4'(op); operand = v; bitIdx = 3'(idx); flagsIn = f; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(req, "done", 16'(done), 16'h1);
    check(req, "result", 16'(resultOut), 16'(e[11:4]));
    check(req, "flags", 16'(flagsOut), 16'(e[3:0]));
    check(req, "writeEn", 16'(writeEn), 16'(e[12]));
  endtask

  task automatic test_reset;
    check("R1", "result", 16'(resultOut), 16'h0);
    check("R1", "flags", 16'(flagsOut), 16'h0);
    check("R1", "writeEn", 16'(writeEn), 16'h0);
    check("R1", "done", 16'(done), 16'h0);
  endtask

  task automatic test_carry_rotates;
    logic [7:0] vals [4] = '{8'h81, 8'h00, 8'h5A, 8'hFF};
    foreach (vals[i]) begin
      runOp("R3", 2, vals[i], 0, 4'b0000);
      runOp("R3", 2, vals[i], 0, 4'b0001);
      runOp("R3", 3, vals[i], 0, 4'b0000);
      runOp("R3", 3, vals[i], 0, 4'b1111);
    end
  endtask

  task automatic test_circular;
    logic [7:0] vals [4] = '{8'h80, 8'h01, 8'hA5, 8'h00};
    foreach (vals[i]) begin
      runOp("R4", 0, vals[i], 0, 4'b0001);
      runOp("R4", 1, vals[i], 0, 4'b1110);
    end
  endtask

  task automatic test_shifts;
    logic [7:0] vals [4] = '{8'h80, 8'h01, 8'hC3, 8'h7E};
    foreach (vals[i]) begin
      runOp("R5", 4, vals[i], 0, 4'b0001);
      runOp("R5", 5, vals[i], 0, 4'b0110);
      runOp("R5", 7, vals[i], 0, 4'b1111);
    end
  endtask

  task automatic test_zero_flag;
    runOp("R6", 4, 8'h80, 0, 4'b0110);
    runOp("R6", 7, 8'h01, 0, 4'b0110);
    runOp("R6", 0, 8'h00, 0, 4'b0111);
    runOp("R6", 5, 8'h02, 0, 4'b1110);
  endtask

  task automatic test_short_forms;
    runOp("R7", 11, 8'h00, 0, 4'b1111);
    runOp("R7", 12, 8'h01, 0, 4'b0000);
    runOp("R7", 13, 8'h80, 0, 4'b0000);
    runOp("R7", 14, 8'h01, 0, 4'b0000);
    runOp("R7", 13, 8'h3C, 0, 4'b0001);
  endtask

  task automatic test_swap;
    runOp("R8", 6, 8'h12, 0, 4'b0111);
    runOp("R8", 6, 8'h00, 0, 4'b0001);
    runOp("R8", 6, 8'hF0, 0, 4'b1000);
  endtask

  task automatic test_bit_test;
    for (int i = 0; i < 8; i++) begin
      runOp("R9", 8, 8'h01 << i, i, 4'b0100);
      runOp("R9", 8, ~(8'h01 << i), i, 4'b0001);
    end
  endtask

  task automatic test_bit_write;
    for (int i = 0; i < 8; i++) begin
      runOp("R10", 9, 8'hFF, i, 4'b1010);
      runOp("R10", 10, 8'h00, i, 4'b0101);
    end
    runOp("R10", 10, 8'h00, 0, 4'b0000);
    check("R10", "index 0 is lsb", 16'(resultOut), 16'h01);
  endtask

  task automatic test_reserved;
    runOp("R11", 15, 8'h6B, 0, 4'b1001);
  endtask

  task automatic test_hold;
    logic [7:0] r0;
    logic [3:0] f0;
    logic w0;
    runOp("R2", 6, 8'hAB, 0, 4'b0000);
    r0 = resultOut; f0 = flagsOut; w0 = writeEn;
    for (int k = 0; k < 3; k++) begin
      operand = 8'h11 * 8'(k + 3); opSel = 4'(k + 8); flagsIn = 4'(k * 5);
      @(negedge clk);
      check("R2", "done low", 16'(done), 16'h0);
      check("R2", "result held", 16'(resultOut), 16'(r0));
      check("R2", "flags held", 16'(flagsOut), 16'(f0));
      check("R2", "writeEn held", 16'(writeEn), 16'(w0));
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_carry_rotates();
    test_circular();
    test_shifts();
    test_zero_flag();
    test_short_forms();
    test_swap();
    test_bit_test();
    test_bit_write();
    test_reserved();
    test_hold();
    finish_run();
  end
endmodule